// File: doc/BRIEF.md
# Triplexed LCD Segment Driver

This block produces the drive-level codes for a multiplexed liquid-crystal display built with three backplane lines and a set of segment lines (thirteen by default). Each segment line crosses all three backplanes, so one line controls three segments. The block receives a segment-on bitmap with three bits per line. For every backplane pin and every segment pin it outputs a 2-bit code that selects ground, one third, two thirds or the full display voltage. An external three-resistor ladder and analog switches turn each code into the pin voltage.

The block cycles through the backplanes in turn, one phase per backplane. After three positive phases it repeats the same three phases with every level mirrored, so no segment sees a DC component. A parameterised prescaler sets the phase length from the system clock. The bitmap is sampled only at the start of a frame, and only once every parameterised number of frames, which sets the slow refresh rate of the shown content. The line count is a parameter, so the narrow ten-line variant is the same design with `NUM_SEG` set to 10.

Top module: `lcd3_mux_drv`

## Requirements
- R1: While `rst` is high at a clock edge, every code in `bp_lvl` and `seg_lvl` becomes 0 at that edge.
- R2: Codes are 0 = ground, 1 = one third, 2 = two thirds, 3 = full. Backplane j sits in `bp_lvl[2*j+1:2*j]`. The phases select backplane 0, then 1, then 2. In a positive phase the selected backplane is at code 3 and the other two are at code 1.
- R3: Bitmap bit `seg_map[3*k+j]` is the segment formed by line k and backplane j, with 1 meaning on. Line k sits in `seg_lvl[2*k+1:2*k]`. In a positive phase, line k is at code 0 when its segment for the selected backplane is on and at code 2 when it is off.
- R4: A frame is the three positive phases followed by the same three phases inverted. In an inverted phase, every backplane code and segment code x is replaced by 3 - x.
- R5: Each phase lasts exactly `PHASE_CYCLES` clock cycles. Output codes change only on the edge that begins a phase. The first phase begins on the first edge at which `rst` is low.
- R6: `seg_map` is sampled on the edge that begins the first frame after reset. After that it is sampled only on the edge that begins every `FRAMES_PER_LATCH`-th frame. Changes to `seg_map` at any other time have no effect on the outputs.
- R7: The eight on/off combinations of the three segments on one line produce eight pairwise distinct segment-line waveforms over a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_map | input | 3*NUM_SEG | Segment-on bitmap, bit 3*k+j is line k at backplane j |
| bp_lvl | output | 6 | Drive-level code for each of the three backplanes, 2 bits each |
| seg_lvl | output | 2*NUM_SEG | Drive-level code for each segment line, 2 bits each |

## Verification
The bench shows an all-off bitmap and an all-on bitmap, which separate the on and off segment levels in both polarities. A bitmap that gives each line a different three-bit pattern checks that every backplane reads its own bit from the bitmap. It also shows that all eight patterns produce eight different line waveforms. A pseudo-random bitmap catches swapped line or bit indices. Between refresh points the bench drives a junk bitmap, which shows whether sampling happens at any time other than the refresh edge. It also samples each phase at its first and last cycle, which catches a wrong phase length and any output change inside a phase.

// File: rtl/lcd3_pkg.sv
package lcd3_pkg;
  localparam int NUM_BP     = 3;
  localparam int NUM_PHASES = 2 * NUM_BP;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND   = 2'd0;
  localparam lvl_t LVL_THIRD = 2'd1;
  localparam lvl_t LVL_TWO3  = 2'd2;
  localparam lvl_t LVL_FULL  = 2'd3;

  // 3 - x on a 2-bit code is its bitwise complement
  function automatic lvl_t mirror(input lvl_t x, input logic inv);
    return inv ? ~x : x;
  endfunction
endpackage

// File: rtl/lcd3_phase_seq.sv
module lcd3_phase_seq #(
  parameter int PHASE_CYCLES     = 8192,
  parameter int FRAMES_PER_LATCH = 5
) (
  input  logic       clk,
  input  logic       rst,
  output logic       run,
  output logic       adv,
  output logic       load,
  output logic [1:0] nxt_bp,
  output logic       nxt_inv
);
  localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam int FW = (FRAMES_PER_LATCH > 1) ? $clog2(FRAMES_PER_LATCH) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYCLES - 1);
  localparam logic [FW-1:0] FR_LAST  = FW'(FRAMES_PER_LATCH - 1);
  localparam logic [2:0]    PH_LAST  = 3'(lcd3_pkg::NUM_PHASES - 1);

  logic [CW-1:0] cnt;
  logic [2:0]    ph, ph_n;
  logic [FW-1:0] fr;
  logic          tick, frame_end;

  assign tick      = run && (cnt == CNT_LAST);
  assign frame_end = tick && (ph == PH_LAST);
  assign load      = !run || (frame_end && (fr == FR_LAST));
  assign adv       = load || tick;

  always_comb begin
    if (!run)          ph_n = 3'd0;
    else if (frame_end) ph_n = 3'd0;
    else if (tick)     ph_n = ph + 3'd1;
    else               ph_n = ph;
  end

  always_comb begin
    nxt_inv = (ph_n >= 3'd3);
    nxt_bp  = nxt_inv ? 2'(ph_n - 3'd3) : ph_n[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
      ph  <= 3'd0;
      fr  <= '0;
    end else begin
      run <= 1'b1;
      if (!run || tick) cnt <= '0;
      else              cnt <= cnt + CW'(1);
      ph <= ph_n;
      if (frame_end) fr <= (fr == FR_LAST) ? '0 : fr + FW'(1);
    end
  end
endmodule

// File: rtl/lcd3_frame_latch.sv
module lcd3_frame_latch #(
  parameter int W = 39
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] view
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // on a load edge the new bitmap feeds the phase that starts there
  assign view = load ? d : q;
endmodule

// File: rtl/lcd3_level_gen.sv
module lcd3_level_gen
  import lcd3_pkg::*;
#(
  parameter int NUM_SEG = 13
) (
  input  logic [3*NUM_SEG-1:0] map,
  input  logic [1:0]           bp_sel,
  input  logic                 inv,
  output logic [2*NUM_BP-1:0]  bp_code,
  output logic [2*NUM_SEG-1:0] seg_code
);
  for (genvar j = 0; j < NUM_BP; j++) begin : g_bp
    lvl_t base;
    assign base = (bp_sel == 2'(j)) ? LVL_FULL : LVL_THIRD;
    assign bp_code[2*j +: 2] = mirror(base, inv);
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    logic [2:0] trio;
    logic       on;
    lvl_t       base;
    assign trio = map[3*k +: 3];
    always_comb begin
      case (bp_sel)
        2'd0:    on = trio[0];
        2'd1:    on = trio[1];
        default: on = trio[2];
      endcase
    end
    assign base = on ? LVL_GND : LVL_TWO3;
    assign seg_code[2*k +: 2] = mirror(base, inv);
  end
endmodule

// File: rtl/lcd3_mux_drv.sv
module lcd3_mux_drv #(
  parameter int NUM_SEG          = 13,
  parameter int PHASE_CYCLES     = 8192,
  parameter int FRAMES_PER_LATCH = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3*NUM_SEG-1:0] seg_map,
  output logic [5:0]           bp_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl
);
  localparam int MW = 3 * NUM_SEG;

  logic          seq_run, upd, latch_en, nxt_inv;
  logic [1:0]    nxt_bp;
  logic [MW-1:0] map_hold, map_view;
  logic [5:0]            bp_d;
  logic [2*NUM_SEG-1:0]  seg_d;

  lcd3_phase_seq #(
    .PHASE_CYCLES    (PHASE_CYCLES),
    .FRAMES_PER_LATCH(FRAMES_PER_LATCH)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .run    (seq_run),
    .adv    (upd),
    .load   (latch_en),
    .nxt_bp (nxt_bp),
    .nxt_inv(nxt_inv)
  );

  lcd3_frame_latch #(.W(MW)) u_latch (
    .clk (clk),
    .rst (rst),
    .load(latch_en),
    .d   (seg_map),
    .q   (map_hold),
    .view(map_view)
  );

  lcd3_level_gen #(.NUM_SEG(NUM_SEG)) u_lvl (
    .map     (map_view),
    .bp_sel  (nxt_bp),
    .inv     (nxt_inv),
    .bp_code (bp_d),
    .seg_code(seg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_lvl  <= '0;
      seg_lvl <= '0;
    end else if (upd) begin
      bp_lvl  <= bp_d;
      seg_lvl <= seg_d;
    end
  end
endmodule

// File: rtl/lcd3_mux_drv_chk.sv
module lcd3_mux_drv_chk #(
  parameter int NUM_SEG = 13
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run,
  input logic                 adv,
  input logic                 load,
  input logic [3*NUM_SEG-1:0] map_q,
  input logic [5:0]           bp_lvl,
  input logic [2*NUM_SEG-1:0] seg_lvl
);
  logic [2:0]         bp_ext, bp_lsb;
  logic [NUM_SEG-1:0] seg_lsb;

  for (genvar j = 0; j < 3; j++) begin : g_b
    assign bp_ext[j] = (bp_lvl[2*j +: 2] == 2'd0) || (bp_lvl[2*j +: 2] == 2'd3);
    assign bp_lsb[j] = bp_lvl[2*j];
  end
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_s
    assign seg_lsb[k] = seg_lvl[2*k];
  end

  // R1: first sample after a reset edge shows all codes at ground
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bp_lvl == '0 && seg_lvl == '0));

  // R2: exactly one backplane at an extreme level once running
  p_one_select_r2: assert property (@(posedge clk) disable iff (rst || !run)
    $countones(bp_ext) == 1);

  // R4: segment and idle-backplane polarity agree across the whole phase
  p_polarity_r4: assert property (@(posedge clk) disable iff (rst || !run)
    ((bp_lsb == 3'b111) && (seg_lsb == '0)) ||
    ((bp_lsb == 3'b000) && (seg_lsb == '1)));

  // R5: outputs move only after a phase-advance enable
  p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bp_lvl) || !$stable(seg_lvl)) |-> ($past(adv) || $past(rst)));

  // R6: held bitmap moves only on a refresh load
  p_latch_only_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(map_q) |-> ($past(load) || $past(rst)));
endmodule

bind lcd3_mux_drv lcd3_mux_drv_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .run    (seq_run),
  .adv    (upd),
  .load   (latch_en),
  .map_q  (map_hold),
  .bp_lvl (bp_lvl),
  .seg_lvl(seg_lvl)
);

// File: tb/sim_lcd3_mux_drv.sv
module sim_lcd3_mux_drv;
  localparam int NS   = 13;
  localparam int MW   = 3 * NS;
  localparam int P    = 4;
  localparam int F    = 2;
  localparam int GPH  = 6 * F;
  localparam int G    = GPH * P;
  localparam int NPAT = 4;

  typedef struct packed {
    logic [5:0]      bp;
    logic [2*NS-1:0] seg;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [MW-1:0] seg_map = '0;
  logic [5:0]    bp_lvl;
  logic [2*NS-1:0] seg_lvl;

  int checks = 0;
  int fails  = 0;
  bit go = 0, mon_done = 0, reported = 0;
  item_t sb[$];

  always #2 clk = ~clk;

  lcd3_mux_drv #(.NUM_SEG(NS), .PHASE_CYCLES(P), .FRAMES_PER_LATCH(F)) u0 (
    .clk(clk), .rst(rst), .seg_map(seg_map), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
  );

  function automatic logic [MW-1:0] pat(int n);
    logic [MW-1:0] m = '0;
    for (int k = 0; k < NS; k++) begin
      case (n)
        0: m[3*k +: 3] = 3'b000;
        1: m[3*k +: 3] = 3'b111;
        2: m[3*k +: 3] = 3'(k % 8);
        default: m[3*k +: 3] = 3'((k * 5 + 3) % 8);
      endcase
    end
    return m;
  endfunction

  function automatic item_t exp_item(logic [MW-1:0] m, int ph);
    item_t it;
    int a = ph % 3;
    bit inv = (ph >= 3);
    int lv;
    for (int j = 0; j < 3; j++) begin
      lv = (j == a) ? 3 : 1;          // R2
      if (inv) lv = 3 - lv;           // R4
      it.bp[2*j +: 2] = 2'(lv);
    end
    for (int k = 0; k < NS; k++) begin
      lv = m[3*k + a] ? 0 : 2;        // R3
      if (inv) lv = 3 - lv;
      it.seg[2*k +: 2] = 2'(lv);
    end
    return it;
  endfunction

  task automatic push_group(logic [MW-1:0] m);
    for (int g = 0; g < GPH; g++) sb.push_back(exp_item(m, g % 6));
  endtask

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  // driver
  initial begin
    seg_map = pat(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bp_lvl == '0 && seg_lvl == '0, "R1", "reset state",
        64'({bp_lvl, seg_lvl}), 64'd0);
    push_group(pat(0));
    rst = 1'b0;
    go  = 1;
    @(posedge clk);
    for (int n = 1; n < NPAT; n++) begin
      repeat (G / 2) @(posedge clk);
      @(negedge clk);
      seg_map = ~pat(n - 1) ^ {MW{1'b1}} ^ MW'(39'h5A3C96E1D);  // junk mid-group, R6
      repeat (G / 2 - 1) @(posedge clk);
      @(negedge clk);
      seg_map = pat(n);
      push_group(pat(n));
    end
    wait (mon_done);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(bp_lvl == '0 && seg_lvl == '0, "R1", "reset mid-run",
        64'({bp_lvl, seg_lvl}), 64'd0);
    report();
    $finish;
  end

  // monitor
  initial begin
    logic [11:0] wave [8];
    item_t e, s;
    bit distinct;
    wait (go);
    for (int g = 0; g < NPAT * GPH; g++) begin
      int grp = g / GPH;
      int lp  = g % GPH;
      int ph  = lp % 6;
      @(negedge clk);
      s.bp = bp_lvl;
      s.seg = seg_lvl;
      if (sb.size() == 0) begin
        chk(0, "R5", "scoreboard empty", 64'(g), 64'd0);
      end else begin
        e = sb.pop_front();
        chk(s.bp == e.bp, (ph < 3) ? "R2" : "R4", "backplane codes",
            64'(s.bp), 64'(e.bp));
        chk(s.seg == e.seg, (grp > 0) ? "R6" : ((ph < 3) ? "R3" : "R4"),
            "segment codes", 64'(s.seg), 64'(e.seg));
      end
      if (grp == 2 && lp < 6)
        for (int k = 0; k < 8; k++) wave[k][2*lp +: 2] = s.seg[2*k +: 2];
      if (grp == 2 && lp == 5) begin
        distinct = 1;
        for (int a = 0; a < 8; a++)
          for (int b = a + 1; b < 8; b++)
            if (wave[a] == wave[b]) distinct = 0;
        chk(distinct, "R7", "eight line waveforms distinct", 64'(distinct), 64'd1);
      end
      repeat (P - 1) @(negedge clk);
      chk(bp_lvl == s.bp && seg_lvl == s.seg, "R5", "codes held through phase",
          64'({bp_lvl, seg_lvl}), 64'({s.bp, s.seg}));
    end
    mon_done = 1;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end
endmodule